// File: doc/BRIEF.md
# Snapshot-Read 64-bit Timer

A free-running 64-bit up-counter made of two 32-bit halves. The upper half advances only on the carry out of the lower half. Software sees the count through a 32-bit register bus with read and write strobes. The bus has no back-pressure: a read strobe is always accepted, and its data appears on `bus_rdata` exactly one clock later.

Reading the low-word register also copies the live upper half into a shadow register on the same clock edge that samples the lower half. The high-word register returns that shadow, not the live upper half. A low read followed by a high read therefore yields one coherent 64-bit value, even when a carry into the upper half lands between the two reads. The block does not arbitrate between readers. A second low-word read placed between another reader's low and high reads replaces the shadow. Software that shares the timer between threads must make each pair of reads uninterruptible.

A control register starts and stops counting and clears the whole timer. Both halves can be loaded from software.

Top module: `tmr64_snap`

## Requirements
- R1: After reset, both count halves, the shadow and both control bits are zero, and `bus_rdata` is zero.
- R2: While the enable bit (bit 0 of the control register at offset 0x00) is 1, the lower half grows by exactly one per clock. While the enable bit is 0, the count holds.
- R3: The upper half increments only in the cycle where the lower half wraps from 0xFFFF_FFFF to 0. Otherwise it holds unless it is loaded or cleared.
- R4: A read of offset 0x10 returns the lower half as it stood at the read edge. On that same edge, the live upper half is copied into the shadow.
- R5: A read of offset 0x14 returns the shadow, not the live upper half. Repeated high reads do not change the shadow.
- R6: A low read directly followed by a high read returns the pre-carry upper word, even if the lower half wraps between them. For example, 0x0000_0000_FFFF_FFFF is read as-is, not as a mix with 0x1.
- R7: A low read issued between another low read and its high read overwrites the shadow. The later high read returns the upper word captured by the most recent low read.
- R8: Writing 1 to bit 1 of the control register zeroes both halves and the shadow on the next edge. Bit 1 then returns to 0 by itself. A read of 0x00 returns the enable bit in bit 0 and the clear bit in bit 1, with zeros above.
- R9: A write to 0x10 or 0x14 loads the lower or upper half. A load of the lower half overrides that cycle's increment.
- R10: Read data has a fixed one-cycle latency. `bus_rdata` is zero in any cycle that follows no read, and it is zero after a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench places a lower-half wrap exactly between a low read and the high read after it. A design that fed the live upper half to high reads would return 0x1 paired with 0xFFFF_FFFF there.

It interleaves a second low read after the upper half has changed, and expects the newer upper word. A design that guarded or queued shadows would return the stale one.

It loads the lower half while counting runs, so a design that let the increment win would read one past the loaded value. It repeats high reads and reads after a clear, which catches a shadow that clears on read or survives a clear. It reads unmapped offsets and idle cycles, which catches read data that is left stale on the bus.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_LO   = 'h10;
  localparam int OFF_HI   = 'h14;  // low offset plus one word
  localparam int CTRL_EN  = 0;
  localparam int CTRL_CLR = 1;
endpackage

// File: rtl/tmr64_half.sv
module tmr64_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         inc,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  // carry out only when this half really steps past all ones
  assign wrap = inc && !load && !clr && (&q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (load)  q <= load_val;
    else if (inc)   q <= q + 1'b1;
  end
endmodule

// File: rtl/tmr64_regs.sv
module tmr64_regs
  import tmr64_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        ctrl_wdata,
  input  logic [W-1:0]      lo,
  input  logic [W-1:0]      hi,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      shadow,
  output logic              en,
  output logic              clr,
  output logic              ld_lo,
  output logic              ld_hi
);
  logic sel_ctrl, sel_lo, sel_hi;

  assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign sel_lo   = (addr == ADDR_W'(OFF_LO));
  assign sel_hi   = (addr == ADDR_W'(OFF_HI));
  assign ld_lo    = wr && sel_lo;
  assign ld_hi    = wr && sel_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      clr <= 1'b0;
    end else if (wr && sel_ctrl) begin
      en  <= ctrl_wdata[CTRL_EN];
      clr <= ctrl_wdata[CTRL_CLR];
    end else begin
      clr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shadow <= '0;
    else if (clr)            shadow <= '0;
    else if (rd && sel_lo)   shadow <= hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (sel_ctrl)    rdata <= {{(W-2){1'b0}}, clr, en};
      else if (sel_lo) rdata <= lo;
      else if (sel_hi) rdata <= shadow;
      else             rdata <= '0;
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/tmr64_snap.sv
module tmr64_snap #(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata
);
  localparam int NHALF = 2;

  logic [HALF_W-1:0] half_q [NHALF];
  logic [NHALF-1:0]  half_inc, half_wrap, half_ld;
  logic [HALF_W-1:0] lo_q, hi_q, shadow_q;
  logic              en, clr, ld_lo, ld_hi, hi_wrap;

  assign half_ld = {ld_hi, ld_lo};

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    if (g == 0) begin : g_first
      assign half_inc[g] = en;
    end else begin : g_chain
      assign half_inc[g] = half_wrap[g-1];
    end
    tmr64_half #(.W(HALF_W)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (half_ld[g]),
      .inc      (half_inc[g]),
      .load_val (bus_wdata),
      .q        (half_q[g]),
      .wrap     (half_wrap[g])
    );
  end

  assign lo_q    = half_q[0];
  assign hi_q    = half_q[1];
  assign hi_wrap = half_wrap[1];

  tmr64_regs #(.W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .ctrl_wdata (bus_wdata[1:0]),
    .lo         (lo_q),
    .hi         (hi_q),
    .rdata      (bus_rdata),
    .shadow     (shadow_q),
    .en         (en),
    .clr        (clr),
    .ld_lo      (ld_lo),
    .ld_hi      (ld_hi)
  );
endmodule

// File: rtl/tmr64_snap_chk.sv
module tmr64_snap_chk
  import tmr64_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              wr_clr,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      lo,
  input logic [W-1:0]      hi,
  input logic [W-1:0]      shadow,
  input logic              en,
  input logic              clr,
  input logic              hi_wrap
);
  logic a_lo, a_hi, a_ctrl;
  assign a_lo   = (bus_addr == ADDR_W'(OFF_LO));
  assign a_hi   = (bus_addr == ADDR_W'(OFF_HI));
  assign a_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));

  // R2
  lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && !(bus_wr && a_lo) |=> lo == $past(lo) + 1'b1);
  // R2
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !clr && !(bus_wr && a_lo) |=> $stable(lo));
  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !(bus_wr && a_hi) && !(en && (&lo) && !(bus_wr && a_lo)) |=> $stable(hi));
  // R3
  hi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wrap |=> hi == '0 && lo == '0);
  // R4
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && a_lo && !clr |=> shadow == $past(hi) && bus_rdata == $past(lo));
  // R5
  hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && a_hi |=> bus_rdata == $past(shadow));
  // R5
  shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !(bus_rd && a_lo) |=> $stable(shadow));
  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> lo == '0 && hi == '0 && shadow == '0);
  // R8
  clr_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(bus_wr && a_ctrl && wr_clr) |=> !clr);
  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);
endmodule

bind tmr64_snap tmr64_snap_chk #(.W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .wr_clr    (bus_wdata[1]),
  .bus_rdata (bus_rdata),
  .lo        (lo_q),
  .hi        (hi_q),
  .shadow    (shadow_q),
  .en        (en),
  .clr       (clr),
  .hi_wrap   (hi_wrap)
);

// File: tb/tmr64_snap_bench.sv
`timescale 1ns/1ps
module tmr64_snap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00, A_LO = 8'h10, A_HI = 8'h14;

  always #5 clk = ~clk;

  tmr64_snap u_tmr64_snap (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd32(A_CTRL, d); check("R1 ctrl after reset", d, 32'h0);
    rd32(A_LO, d);   check("R1 low after reset", d, 32'h0);
    rd32(A_HI, d);   check("R1 high after reset", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr32(A_LO, 32'd10); wr32(A_HI, 32'd0);
    wr32(A_CTRL, 32'h1);
    rd32(A_LO, d); check("R2 first count", d, 32'd10);
    rd32(A_LO, d); check("R2 one step per clock", d, 32'd11);
    wr32(A_CTRL, 32'h0);
    rd32(A_LO, d); check("R2 stopped value", d, 32'd13);
    rd32(A_LO, d); check("R2 hold when disabled", d, 32'd13);
    rd32(A_HI, d); check("R3 no carry without wrap", d, 32'd0);
    rd32(A_CTRL, d); check("R8 ctrl readback", d, 32'h0);
  endtask

  task automatic t_carry_snapshot();
    logic [31:0] d;
    wr32(A_LO, 32'hFFFF_FFFF); wr32(A_HI, 32'h0);
    wr32(A_CTRL, 32'h1);
    rd32(A_LO, d); check("R6 low before carry", d, 32'hFFFF_FFFF);
    rd32(A_HI, d); check("R6 pre-carry high word", d, 32'h0);
    wr32(A_CTRL, 32'h0);
    rd32(A_LO, d); check("R3 low after wrap", d, 32'd2);
    rd32(A_HI, d); check("R3 high stepped once", d, 32'd1);
  endtask

  task automatic t_shadow_hold();
    logic [31:0] d;
    wr32(A_LO, 32'd1); wr32(A_HI, 32'h20);
    rd32(A_LO, d); check("R4 low read value", d, 32'd1);
    wr32(A_HI, 32'h30);
    rd32(A_HI, d); check("R5 high from shadow not live", d, 32'h20);
    rd32(A_HI, d); check("R5 repeated high read", d, 32'h20);
    rd32(A_LO, d);
    rd32(A_HI, d); check("R4 new capture of live high", d, 32'h30);
  endtask

  task automatic t_overwrite();
    logic [31:0] a_lo, b_lo, d;
    wr32(A_LO, 32'hFFFF_FFF0); wr32(A_HI, 32'd7);
    rd32(A_LO, a_lo);
    wr32(A_HI, 32'd9);
    rd32(A_LO, b_lo);
    rd32(A_HI, d);
    check("R7 second low read low", b_lo, 32'hFFFF_FFF0);
    check("R7 first reader gets newer high", d, 32'd9);
    check("R7 first reader low unchanged", a_lo, 32'hFFFF_FFF0);
  endtask

  task automatic t_load_priority();
    logic [31:0] d;
    wr32(A_CTRL, 32'h1);
    wr32(A_LO, 32'd100);
    rd32(A_LO, d); check("R9 load beats increment", d, 32'd100);
    wr32(A_CTRL, 32'h0);
    wr32(A_HI, 32'hABCD);
    rd32(A_LO, d);
    rd32(A_HI, d); check("R9 high load", d, 32'hABCD);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr32(A_LO, 32'h1234); wr32(A_HI, 32'h55);
    rd32(A_LO, d);
    wr32(A_CTRL, 32'h2);
    @(posedge clk); @(negedge clk);
    rd32(A_CTRL, d); check("R8 clear bit self-clears", d, 32'h0);
    rd32(A_HI, d);   check("R8 shadow cleared", d, 32'h0);
    rd32(A_LO, d);   check("R8 low cleared", d, 32'h0);
    rd32(A_HI, d);   check("R8 high cleared", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr32(A_LO, 32'h77);
    rd32(8'h04, d); check("R10 unmapped read zero", d, 32'h0);
    rd32(8'h18, d); check("R10 unmapped read zero 2", d, 32'h0);
    rd32(A_LO, d);  check("R10 one-cycle latency", d, 32'h77);
    @(posedge clk); @(negedge clk);
    check("R10 idle rdata zero", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_carry_snapshot();
    t_shadow_hold();
    t_overwrite();
    t_load_priority();
    t_clear();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule